// File: doc/BRIEF.md
# Sector Write-Protection Manager

This block holds the protection state of a memory array made of uniform sectors (128 by default) and answers, for every program or erase request, whether the target sector may be written. Each sector owns three state bits: a persistent protect bit, a volatile dynamic protect bit, and a volatile temporary-unprotect mask bit. For all three, a value of 0 means "set" and 1 means "cleared". A single volatile lock bit, cleared only by a hardware reset or a power-up event, freezes the persistent bits and the mask bits.

Software drives a one-cycle command port that carries an operation code and a sector index. Dynamic and mask changes take effect at once. Persistent-bit changes run for a fixed number of cycles. During that time the busy output is high and status reads show a toggling bit 6. When the change ends, the status byte holds a completion code. A separate request port takes a sector index and returns, one cycle later, an acknowledge together with an allow flag. An active-low write-protect pin also protects one configurable boundary sector.

Top module: `sect_guard`

## Requirements
- R1: After power-up and hardware reset, busy is 0, the status byte is 0x00, the request acknowledge is 0, and a status query of any sector returns 0x0F. Persistent bits start at 1.
- R2: Operation codes are 0 no-op, 1 persistent set, 2 persistent clear, 3 dynamic set, 4 dynamic clear, 5 mask set, 6 mask clear, 7 lock, 8 query. A dynamic set or clear writes 0 or 1 to the addressed sector only. The write is visible to the next query.
- R3: A sector is protected when its dynamic bit is 0, or when its persistent bit is 0 and its mask bit is 1.
- R4: When a sector's mask bit is 0 and its dynamic bit is 1, its persistent bit has no effect and the sector is writable.
- R5: While the write-protect pin is 0, the boundary sector (default 127) is protected whatever its bits hold. Every other sector is unaffected by the pin.
- R6: Opcode 7 sets the lock bit to 0. While the lock is 0, mask set and mask clear are ignored. A persistent operation still runs its full busy time, but it leaves the bit unchanged and ends with code 0x20.
- R7: No command returns the lock bit to 1. Only hardware reset or power-up does that.
- R8: A hardware reset keeps every persistent, dynamic and mask bit. It returns the lock bit to 1 and aborts any persistent operation.
- R9: A power-up event sets every dynamic and mask bit to 1 and the lock bit to 1. It keeps every persistent bit.
- R10: A persistent operation holds busy high for exactly BUSY_CYC cycles. Every query during that time returns 0 in all bits except bit 6, which inverts from one query to the next. Every command other than a query is ignored while busy.
- R11: At the end of a persistent operation the status byte reads 0x00 after a set and 0x01 after a clear (0x20 on failure). The addressed persistent bit takes its new value at that moment.
- R12: A request presented in one cycle is answered in the next cycle with the acknowledge high and allow high exactly when the sector is not protected.
- R13: A query result puts the persistent bit at bit 0, the dynamic bit at bit 1, the mask bit at bit 2 and the lock bit at bit 3, with bits 7 to 4 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| por | input | 1 | Synchronous power-up event, active high |
| wp_n | input | 1 | Write-protect pin, active low, guards the boundary sector |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Operation code |
| cmd_sect | input | SECT_W (7) | Sector index of the command |
| req_valid | input | 1 | Program/erase request strobe |
| req_sect | input | SECT_W (7) | Sector index of the request |
| req_ack | output | 1 | Request answered this cycle |
| req_allow | output | 1 | Request may proceed |
| busy | output | 1 | Persistent-bit operation in progress |
| stat | output | 8 | Status byte |

## Verification
The bench targets the mask override (persistent bit 0, mask 0, dynamic 1). A design that decodes the override wrongly denies that sector, or lets a dynamic-protected sector through. It also checks survival across hardware reset: a design that clears the volatile bits on reset, or leaves the lock stuck at 0, shows the wrong query bytes afterwards. Persistent operations are timed cycle by cycle. A design with an off-by-one busy window, a bit 6 that does not toggle between queries, or a command taken while busy shows the wrong busy count, status byte or dynamic bit. Locked operations must run the full busy time, end with 0x20, and leave the persistent bit unchanged.

// File: rtl/sect_guard_pkg.sv
// Package: shared operation codes, status codes and the protection rule.
package sect_guard_pkg;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_PSET  = 4'd1,
        OP_PCLR  = 4'd2,
        OP_DSET  = 4'd3,
        OP_DCLR  = 4'd4,
        OP_USET  = 4'd5,
        OP_UCLR  = 4'd6,
        OP_LOCK  = 4'd7,
        OP_QUERY = 4'd8
    } sg_op_e;

    localparam logic [7:0] ST_PROG_OK  = 8'h00;
    localparam logic [7:0] ST_ERASE_OK = 8'h01;
    localparam logic [7:0] ST_FAIL     = 8'h20;
    localparam int         ST_TOG_BIT  = 6;

    // Protection rule: dynamic set, or persistent set without a mask override, or pin hit.
    function automatic logic sg_protected(input logic p, input logic d,
                                          input logic u, input logic wp_hit);
        return (!d) || (!p && u) || wp_hit;
    endfunction

endpackage

// File: rtl/sg_bitbank.sv
// Per-sector state storage: persistent, dynamic and mask bits for every sector.
// Assumes NUM_SECT is a power of two so every index value names a sector.
// Power-up returns the volatile bits to 1; hardware reset leaves all bits alone.
module sg_bitbank #(
    parameter int NUM_SECT = 128,
    localparam int SECT_W  = $clog2(NUM_SECT)
) (
    input  logic              clk,
    input  logic              por,
    input  logic              d_we,
    input  logic              d_val,
    input  logic              u_we,
    input  logic              u_val,
    input  logic [SECT_W-1:0] vsel,
    input  logic              p_we,
    input  logic              p_val,
    input  logic [SECT_W-1:0] psel,
    input  logic [SECT_W-1:0] rsel_a,
    input  logic [SECT_W-1:0] rsel_b,
    output logic              p_a,
    output logic              d_a,
    output logic              u_a,
    output logic              p_b,
    output logic              d_b,
    output logic              u_b
);
    logic [NUM_SECT-1:0] p_vec;
    logic [NUM_SECT-1:0] d_vec;
    logic [NUM_SECT-1:0] u_vec;

    for (genvar i = 0; i < NUM_SECT; i++) begin : g_sect
        logic p_r = 1'b1;
        logic d_r;
        logic u_r;

        // Volatile bits: forced to 1 on power-up, else written when addressed.
        always_ff @(posedge clk) begin
            if (por) begin
                d_r <= 1'b1;
                u_r <= 1'b1;
            end else begin
                if (d_we && (vsel == SECT_W'(i))) d_r <= d_val;
                if (u_we && (vsel == SECT_W'(i))) u_r <= u_val;
            end
        end

        // Persistent bit: written only by the sequencer at completion.
        always_ff @(posedge clk) begin
            if (p_we && (psel == SECT_W'(i))) p_r <= p_val;
        end

        assign p_vec[i] = p_r;
        assign d_vec[i] = d_r;
        assign u_vec[i] = u_r;
    end

    assign p_a = p_vec[rsel_a];
    assign d_a = d_vec[rsel_a];
    assign u_a = u_vec[rsel_a];
    assign p_b = p_vec[rsel_b];
    assign d_b = d_vec[rsel_b];
    assign u_b = u_vec[rsel_b];

endmodule

// File: rtl/sg_pers_seq.sv
// Persistent-bit sequencer: runs one set/clear for BUSY_CYC cycles, then
// writes the bit (unless the lock was set at start) and reports a code.
// Assumes the caller never starts it while busy.
module sg_pers_seq
    import sect_guard_pkg::*;
#(
    parameter int NUM_SECT = 128,
    parameter int BUSY_CYC = 8,
    localparam int SECT_W  = $clog2(NUM_SECT),
    localparam int CNT_W   = $clog2(BUSY_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por,
    input  logic              start,
    input  logic              start_clr,
    input  logic [SECT_W-1:0] start_sect,
    input  logic              locked,
    output logic              busy,
    output logic              done,
    output logic [7:0]        done_code,
    output logic              p_we,
    output logic              p_val,
    output logic [SECT_W-1:0] p_sel
);
    logic [CNT_W-1:0]  cnt_q;
    logic              clr_q;
    logic              fail_q;
    logic [SECT_W-1:0] sect_q;

    // Operation timer and captured operands.
    always_ff @(posedge clk) begin
        if (!rst_n || por) begin
            busy   <= 1'b0;
            cnt_q  <= '0;
            clr_q  <= 1'b0;
            fail_q <= 1'b0;
            sect_q <= '0;
        end else if (start && !busy) begin
            busy   <= 1'b1;
            cnt_q  <= CNT_W'(BUSY_CYC - 1);
            clr_q  <= start_clr;
            fail_q <= locked;
            sect_q <= start_sect;
        end else if (busy) begin
            if (cnt_q == '0) busy <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    // Completion outputs.
    always_comb begin
        done      = busy && (cnt_q == '0);
        p_we      = done && !fail_q;
        p_val     = clr_q;
        p_sel     = sect_q;
        done_code = fail_q ? ST_FAIL : (clr_q ? ST_ERASE_OK : ST_PROG_OK);
    end

endmodule

// File: rtl/sg_status.sv
// Status byte register: completion codes, busy toggle reads and sector reports.
// A completion in the same cycle as a query takes precedence.
module sg_status
    import sect_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       query,
    input  logic       busy,
    input  logic       done,
    input  logic [7:0] done_code,
    input  logic       p_bit,
    input  logic       d_bit,
    input  logic       u_bit,
    input  logic       lock_n,
    output logic [7:0] stat
);
    logic tog_q;

    // Load the status byte from the highest-priority source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat  <= 8'h00;
            tog_q <= 1'b0;
        end else if (done) begin
            stat  <= done_code;
        end else if (query && busy) begin
            tog_q <= !tog_q;
            stat  <= 8'(!tog_q) << ST_TOG_BIT;
        end else if (query) begin
            stat  <= {4'b0000, lock_n, u_bit, d_bit, p_bit};
        end
    end

endmodule

// File: rtl/sect_guard.sv
// Top: decodes commands, holds the lock bit, and answers program/erase
// requests one cycle after they arrive. Reset and power-up are synchronous.
module sect_guard
    import sect_guard_pkg::*;
#(
    parameter int NUM_SECT      = 128,
    parameter int BUSY_CYC      = 8,
    parameter int BOUNDARY_SECT = NUM_SECT - 1,
    localparam int SECT_W       = $clog2(NUM_SECT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por,
    input  logic              wp_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [SECT_W-1:0] cmd_sect,
    input  logic              req_valid,
    input  logic [SECT_W-1:0] req_sect,
    output logic              req_ack,
    output logic              req_allow,
    output logic              busy,
    output logic [7:0]        stat
);
    sg_op_e            op;
    logic              acc;
    logic              lock_n;
    logic              d_we, d_val, u_we, u_val;
    logic              ps_start, ps_clr;
    logic              seq_done, p_we, p_val;
    logic [SECT_W-1:0] p_sel;
    logic [7:0]        done_code;
    logic              p_a, d_a, u_a, p_b, d_b, u_b;
    logic              wp_hit;

    // Command decode; only queries are taken while busy.
    always_comb begin
        op       = sg_op_e'(cmd_op);
        acc      = cmd_valid && !busy && !por;
        d_we     = acc && (op == OP_DSET || op == OP_DCLR);
        d_val    = (op == OP_DCLR);
        u_we     = acc && lock_n && (op == OP_USET || op == OP_UCLR);
        u_val    = (op == OP_UCLR);
        ps_start = acc && (op == OP_PSET || op == OP_PCLR);
        ps_clr   = (op == OP_PCLR);
        wp_hit   = !wp_n && (req_sect == SECT_W'(BOUNDARY_SECT));
    end

    // Global lock: set by command, cleared only by reset or power-up.
    always_ff @(posedge clk) begin
        if (!rst_n || por)                lock_n <= 1'b1;
        else if (acc && op == OP_LOCK)    lock_n <= 1'b0;
    end

    // Request verdict, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_ack   <= 1'b0;
            req_allow <= 1'b0;
        end else begin
            req_ack   <= req_valid;
            req_allow <= req_valid && !sg_protected(p_b, d_b, u_b, wp_hit);
        end
    end

    sg_bitbank #(.NUM_SECT(NUM_SECT)) u_bank (
        .clk(clk), .por(por),
        .d_we(d_we), .d_val(d_val), .u_we(u_we), .u_val(u_val), .vsel(cmd_sect),
        .p_we(p_we), .p_val(p_val), .psel(p_sel),
        .rsel_a(cmd_sect), .rsel_b(req_sect),
        .p_a(p_a), .d_a(d_a), .u_a(u_a), .p_b(p_b), .d_b(d_b), .u_b(u_b)
    );

    sg_pers_seq #(.NUM_SECT(NUM_SECT), .BUSY_CYC(BUSY_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .por(por),
        .start(ps_start), .start_clr(ps_clr), .start_sect(cmd_sect),
        .locked(!lock_n),
        .busy(busy), .done(seq_done), .done_code(done_code),
        .p_we(p_we), .p_val(p_val), .p_sel(p_sel)
    );

    sg_status u_stat (
        .clk(clk), .rst_n(rst_n),
        .query(cmd_valid && op == OP_QUERY),
        .busy(busy), .done(seq_done), .done_code(done_code),
        .p_bit(p_a), .d_bit(d_a), .u_bit(u_a), .lock_n(lock_n),
        .stat(stat)
    );

endmodule

// File: rtl/sect_guard_chk.sv
// Checker: temporal properties of the protection manager, bound to the top.
module sect_guard_chk
    import sect_guard_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       por,
    input logic       lock_n,
    input logic       busy,
    input logic       seq_done,
    input logic       p_we,
    input logic       cmd_valid,
    input logic [3:0] cmd_op,
    input logic       req_valid,
    input logic       req_ack,
    input logic       req_allow,
    input logic [7:0] stat
);
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_n && !por) |=> !lock_n);                                         // R7
    AST_LOCK_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_LOCK && !busy && !por) |=> !lock_n);         // R6
    AST_POR_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        por |=> lock_n);                                                        // R9
    AST_LOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        p_we |-> lock_n);                                                       // R6
    AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(cmd_valid) &&
                         ($past(cmd_op) == OP_PSET || $past(cmd_op) == OP_PCLR))); // R10
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !busy);                                                    // R10
    AST_BUSY_QUERY_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_QUERY && busy && !seq_done && !por)
        |=> (stat[7] == 1'b0 && stat[5:0] == 6'd0));                            // R10
    AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> req_ack);                                                 // R12
    AST_ALLOW_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        req_allow |-> req_ack);                                                 // R12
endmodule

bind sect_guard sect_guard_chk u_chk (
    .clk(clk), .rst_n(rst_n), .por(por), .lock_n(lock_n), .busy(busy),
    .seq_done(seq_done), .p_we(p_we), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .req_valid(req_valid), .req_ack(req_ack), .req_allow(req_allow), .stat(stat)
);

// File: tb/sim_sect_guard.sv
`timescale 1ns/1ps
module sim_sect_guard;
    localparam int NS = 128;
    localparam int BC = 8;
    localparam int BOUND = 127;
    localparam logic [3:0] C_PSET = 4'd1, C_PCLR = 4'd2, C_DSET = 4'd3, C_DCLR = 4'd4,
                           C_USET = 4'd5, C_UCLR = 4'd6, C_LOCK = 4'd7, C_QRY = 4'd8;

    logic clk = 1'b0, rst_n = 1'b0, por = 1'b1, wp_n = 1'b1;
    logic cmd_valid = 1'b0, req_valid = 1'b0;
    logic [3:0] cmd_op = 4'd0;
    logic [6:0] cmd_sect = 7'd0, req_sect = 7'd0;
    logic req_ack, req_allow, busy;
    logic [7:0] stat;

    int n_chk = 0, n_bad = 0;
    logic mp[NS], md[NS], mu[NS];
    logic mlock;

    always #5 clk = ~clk;

    sect_guard u0 (.clk(clk), .rst_n(rst_n), .por(por), .wp_n(wp_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_sect(cmd_sect),
        .req_valid(req_valid), .req_sect(req_sect), .req_ack(req_ack),
        .req_allow(req_allow), .busy(busy), .stat(stat));

    function automatic logic [7:0] exp_q(input int s);
        return {4'b0000, mlock, mu[s], md[s], mp[s]};
    endfunction

    function automatic logic exp_allow(input int s, input logic wp);
        return !(!md[s] || (!mp[s] && mu[s]) || (!wp && s == BOUND));
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic cmd(input logic [3:0] op, input int s);
        @(negedge clk); cmd_valid = 1'b1; cmd_op = op; cmd_sect = 7'(s);
        @(negedge clk); cmd_valid = 1'b0;
        case (op)
            C_DSET: md[s] = 1'b0;
            C_DCLR: md[s] = 1'b1;
            C_USET: if (mlock) mu[s] = 1'b0;
            C_UCLR: if (mlock) mu[s] = 1'b1;
            C_LOCK: mlock = 1'b0;
            default: ;
        endcase
    endtask

    task automatic query(input string tag, input int s);
        cmd(C_QRY, s);
        chk(tag, 32'(stat), 32'(exp_q(s)));
    endtask

    task automatic request(input string tag, input int s);
        @(negedge clk); req_valid = 1'b1; req_sect = 7'(s);
        @(negedge clk); req_valid = 1'b0;
        chk(tag, {30'd0, req_ack, req_allow}, {30'd0, 1'b1, exp_allow(s, wp_n)});
    endtask

    // Persistent operation: times busy, checks toggle, tries an ignored command.
    task automatic pers_op(input logic [3:0] op, input int s);
        int n = 0;
        logic b6a, b6b, d_before;
        logic [7:0] code;
        d_before = md[s];
        @(negedge clk); cmd_valid = 1'b1; cmd_op = op; cmd_sect = 7'(s);
        @(negedge clk); n += int'(busy); cmd_op = C_QRY;
        @(negedge clk); n += int'(busy); b6a = stat[6];
        chk("R10 busy query form", 32'(stat & 8'hBF), 32'h0);
        @(negedge clk); n += int'(busy); b6b = stat[6];
        cmd_op = d_before ? C_DSET : C_DCLR;
        @(negedge clk); n += int'(busy); cmd_valid = 1'b0;
        chk("R10 bit6 toggles", 32'(b6a ^ b6b), 32'd1);
        forever begin
            @(negedge clk);
            if (!busy) break;
            n++;
        end
        chk("R10 busy length", 32'(n), 32'(BC));
        if (!mlock) code = 8'h20;
        else begin
            code = (op == C_PCLR) ? 8'h01 : 8'h00;
            mp[s] = (op == C_PCLR);
        end
        chk("R11 completion code", 32'(stat), 32'(code));
        query("R10 command ignored while busy", s);
    endtask

    task automatic hw_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        mlock = 1'b1;
    endtask

    task automatic power_up();
        @(negedge clk); por = 1'b1;
        @(negedge clk); por = 1'b0;
        for (int i = 0; i < NS; i++) begin md[i] = 1'b1; mu[i] = 1'b1; end
        mlock = 1'b1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NS; i++) begin mp[i] = 1'b1; md[i] = 1'b1; mu[i] = 1'b1; end
        mlock = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; por = 1'b0;
        @(negedge clk);
        chk("R1 reset outputs", {22'd0, busy, req_ack, stat}, 32'h0);
        query("R1 query sector 0", 0);
        query("R13 query boundary", BOUND);
        chk("R1 initial byte", 32'(stat), 32'h0F);

        cmd(C_DSET, 5);
        query("R2 dynamic set", 5);
        query("R2 neighbour untouched", 6);
        request("R3 dynamic protect", 5);
        cmd(C_DCLR, 5);
        request("R2 dynamic clear", 5);

        pers_op(C_PSET, 9);
        query("R11 persistent set seen", 9);
        request("R3 persistent protect", 9);
        cmd(C_USET, 9);
        query("R13 mask set byte", 9);
        request("R4 mask override", 9);
        cmd(C_DSET, 9);
        request("R3 dynamic beats mask", 9);
        cmd(C_DCLR, 9);

        wp_n = 1'b0;
        request("R5 pin protects boundary", BOUND);
        request("R5 pin leaves others", BOUND - 1);
        wp_n = 1'b1;
        request("R5 pin released", BOUND);

        for (int k = 0; k < 500; k++) begin
            int r, s;
            r = int'($urandom % 6);
            s = ($urandom % 4 == 0) ? BOUND : int'($urandom % NS);
            if (s == 9) s = 10;
            wp_n = 1'($urandom % 2);
            case (r)
                0: cmd(C_DSET, s);
                1: cmd(C_DCLR, s);
                2: cmd(C_USET, s);
                3: cmd(C_UCLR, s);
                4: request("R3 random request", s);
                default: query("R2 random query", s);
            endcase
        end
        wp_n = 1'b1;

        cmd(C_DSET, 20); cmd(C_USET, 21);
        hw_reset();
        query("R8 dynamic kept", 20);
        query("R8 mask kept", 21);
        query("R8 persistent kept", 9);

        cmd(C_LOCK, 0);
        query("R6 lock shown", 9);
        cmd(C_UCLR, 9);
        query("R6 mask frozen", 9);
        pers_op(C_PCLR, 9);
        query("R6 persistent unchanged", 9);
        cmd(C_DCLR, 20); cmd(C_QRY, 3); cmd(4'd0, 0);
        query("R7 commands keep lock", 20);
        hw_reset();
        query("R7 reset clears lock", 9);
        pers_op(C_PCLR, 9);
        query("R11 persistent clear seen", 9);
        pers_op(C_PSET, 40);

        power_up();
        for (int i = 0; i < NS; i++) query("R9 power-up state", i);
        chk("R9 persistent survives", 32'(mp[40]), 32'd0);

        finish_run();
    end
endmodule